// File: doc/BRIEF.md
# Pivoting Gauss-Jordan Matrix Inverter

This block inverts a square matrix of up to `N_MAX` rows in place. It uses Gauss-Jordan elimination with partial pivoting in signed fixed point. Two storage arrays hold the work: one holds the matrix being reduced and one starts as the identity. Every row operation is applied to both arrays in the same cycle. When the run ends, the array that started as the identity holds the inverse.

Software writes the matrix one row per cycle through the load port and then pulses start with the active size. While rows arrive, the block tracks the row with the largest magnitude in the first column, so the first pivot is already known. Each column then goes through a fixed sequence. First the current row is swapped with the pivot row. Next a multi-cycle divider forms the pivot's reciprocal. The pivot row is then scaled by that reciprocal into a row cache. Finally every other row is updated, `LANES` elements per half per cycle. A magnitude comparator at the elimination output watches the next column and picks the next pivot, so no separate search pass is needed. A zero pivot stops the run with the singular flag set.

Top module: `gj_inverter`

## Requirements
- R1: After reset, busy_o, done_o and singular_o are all low.
- R2: Element j of a loaded row sits in ld_data_i[j*DW +: DW] as a two's complement value with FB fraction bits. Loading row r also sets row r of the second array to the identity row. After done_o rises on an invertible, well-conditioned matrix, rd_data_o at (rd_row_i, rd_col_i) gives the inverse element to within 16 LSB.
- R3: In each column, the pivot is the row at or below the current row with the largest magnitude, and ties go to the lowest index. Matrices with zeros on the diagonal invert correctly through row swaps.
- R4: The first pivot is taken from magnitudes tracked during loading. Writing row 0 restarts the tracking, so row 0 must be loaded first. A matrix whose entry at row 0, column 0 is zero inverts correctly.
- R5: If the chosen pivot is exactly zero, the run stops and done_o and singular_o rise together. For an invertible matrix, singular_o stays low.
- R6: A start pulse while busy_o is high has no effect on the size, the result or the completion time.
- R7: n_i selects the active size, from 1 to N_MAX, and is sampled on the start cycle. Matrices of sizes 1, 2, 3 and 4 invert correctly.
- R8: For an invertible matrix, done_o rises exactly n·(2·FB+6+n·ceil(n/LANES)) clock edges after the edge that samples start_i. This count includes the reciprocal stall, the lane sweep and the search-free pivot selection.
- R9: Normalization multiplies by a reciprocal of magnitude floor(2^(2·FB)/|p|), where p is the raw pivot code; the result is saturated to the largest positive code and negated for a negative pivot. A 1×1 matrix holding 3.0 yields exactly code 1365 when FB=12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin inversion (ignored while busy) |
| n_i | input | $clog2(N_MAX+1) | Active matrix size |
| ld_en_i | input | 1 | Write one row |
| ld_row_i | input | $clog2(N_MAX) | Row being written |
| ld_data_i | input | N_MAX*DW | Row elements, element j at [j*DW +: DW] |
| rd_row_i | input | $clog2(N_MAX) | Result row to read |
| rd_col_i | input | $clog2(N_MAX) | Result column to read |
| rd_data_o | output | DW | Inverse element, combinational read |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished, held until the next start |
| singular_o | output | 1 | Zero pivot met, valid with done_o |

## Verification
The completion flag is due a fixed number of edges after start: n·(2·FB+6+n·ceil(n/LANES)) for an invertible matrix. The bench counts rising edges from the edge that samples start and samples done_o at each falling edge, so the count it compares with the formula is exact. The read port is combinational, so results are read after done_o is seen, with a short settle delay. The singular flag is checked at the same sample as done_o. The stray-start test injects a pulse mid-run and still expects the original completion edge.

// File: rtl/gj_pkg.sv
package gj_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_SWAP, S_RECIP, S_NORM, S_NWAIT, S_ELIM, S_DRAIN
  } gj_state_e;
endpackage

// File: rtl/gj_recip.sv
module gj_recip #(
  parameter int DW = 24,
  parameter int FB = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [DW-1:0]        den_i,
  output logic                 valid_o,
  output logic signed [DW-1:0] q_o
);
  localparam int NUMW = 2*FB + 1;
  localparam int CW   = $clog2(NUMW + 1);
  localparam logic [NUMW+DW-1:0] QMAX = {{(NUMW+1){1'b0}}, {(DW-1){1'b1}}};

  logic [DW:0]      rem_q, shifted;
  logic [NUMW-1:0]  quo_q;
  logic [DW-1:0]    den_q;
  logic [CW-1:0]    cnt_q;
  logic             run_q, ge;
  logic [NUMW+DW-1:0] wide;

  // dividend is a single 1 followed by zeros
  always_comb begin
    shifted = {rem_q[DW-1:0], (cnt_q == '0)};
    ge      = shifted >= {1'b0, den_q};
    wide    = {{DW{1'b0}}, quo_q};
    q_o     = (wide > QMAX) ? {1'b0, {(DW-1){1'b1}}} : wide[DW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0; quo_q <= '0; den_q <= '0; cnt_q <= '0;
      run_q <= 1'b0; valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (start_i) begin
        run_q <= 1'b1; rem_q <= '0; quo_q <= '0; cnt_q <= '0; den_q <= den_i;
      end else if (run_q) begin
        rem_q <= ge ? shifted - {1'b0, den_q} : shifted;
        quo_q <= {quo_q[NUMW-2:0], ge};
        cnt_q <= cnt_q + CW'(1);
        if (int'(cnt_q) == NUMW-1) begin
          run_q   <= 1'b0;
          valid_o <= 1'b1;
        end
      end
    end
  end

  p_valid_after_run_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run_q) |-> valid_o);
  p_no_valid_while_run_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> !valid_o);
endmodule

// File: rtl/gj_lane.sv
module gj_lane #(
  parameter int DW = 24,
  parameter int FB = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sub_i,
  input  logic signed [DW-1:0] acc_i,
  input  logic signed [DW-1:0] mul_a_i,
  input  logic signed [DW-1:0] mul_b_i,
  output logic signed [DW-1:0] y_o
);
  logic signed [2*DW-1:0] prod, prod_sh;

  always_comb begin
    prod    = mul_a_i * mul_b_i;
    prod_sh = prod >>> FB;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) y_o <= '0;
    else         y_o <= sub_i ? acc_i - prod_sh[DW-1:0] : prod_sh[DW-1:0];
  end
endmodule

// File: rtl/gj_inverter.sv
module gj_inverter
  import gj_pkg::*;
#(
  parameter int N_MAX = 4,
  parameter int DW    = 24,
  parameter int FB    = 12,
  parameter int LANES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [$clog2(N_MAX+1)-1:0] n_i,
  input  logic                  ld_en_i,
  input  logic [$clog2(N_MAX)-1:0] ld_row_i,
  input  logic [N_MAX*DW-1:0]   ld_data_i,
  input  logic [$clog2(N_MAX)-1:0] rd_row_i,
  input  logic [$clog2(N_MAX)-1:0] rd_col_i,
  output logic signed [DW-1:0]  rd_data_o,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  singular_o
);
  localparam int RW     = $clog2(N_MAX);
  localparam int NW     = $clog2(N_MAX+1);
  localparam int CH_MAX = (N_MAX + LANES - 1) / LANES;
  localparam int CHW    = (CH_MAX > 1) ? $clog2(CH_MAX) : 1;
  localparam logic signed [DW-1:0] ONE = DW'(1 << FB);

  function automatic logic [DW-1:0] mag(input logic signed [DW-1:0] v);
    return v[DW-1] ? DW'(-v) : DW'(v);
  endfunction

  gj_state_e state;
  logic signed [DW-1:0] mat_a [N_MAX][N_MAX];
  logic signed [DW-1:0] mat_b [N_MAX][N_MAX];
  logic signed [DW-1:0] row_ca [N_MAX], row_cb [N_MAX], col_c [N_MAX];
  logic signed [DW-1:0] recip_q, piv_val, rec_q;
  logic [DW-1:0]   piv_mag_q, ld_mag;
  logic [NW-1:0]   n_q;
  logic [RW-1:0]   col_q, row_q, piv_row_q, wb_row_q, wb_tgt;
  logic [CHW-1:0]  ch_q, wb_ch_q;
  logic            wb_val_q, wb_norm_q, rec_neg_q, rec_start, rec_valid, issue, last_ch;
  logic            sub_en;
  logic signed [DW-1:0] ya [LANES], yb [LANES];
  int              wb_col [LANES];
  logic            wb_ok  [LANES];
  logic [DW-1:0]   ya_mag [LANES];

  always_comb begin
    piv_val   = mat_a[piv_row_q][col_q];
    rec_start = (state == S_SWAP) && (piv_val != '0);
    issue     = (state == S_NORM) || ((state == S_ELIM) && (row_q != col_q));
    last_ch   = int'(ch_q) == ((int'(n_q) + LANES - 1) / LANES) - 1;
    sub_en    = (state != S_NORM);
    ld_mag    = mag(ld_data_i[DW-1:0]);
    wb_tgt    = wb_norm_q ? col_q : wb_row_q;
    busy_o    = (state != S_IDLE);
    rd_data_o = mat_b[rd_row_i][rd_col_i];
  end

  gj_recip #(.DW(DW), .FB(FB)) i_recip (
    .clk_i, .rst_ni, .start_i(rec_start), .den_i(mag(piv_val)),
    .valid_o(rec_valid), .q_o(rec_q)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    int              c_l;
    logic [RW-1:0]   ci_l;
    logic signed [DW-1:0] acc_a, acc_b, m_l, pa_l, pb_l;
    always_comb begin
      c_l   = int'(ch_q) * LANES + l;
      ci_l  = (c_l < N_MAX) ? RW'(c_l) : '0;
      m_l   = sub_en ? col_c[row_q] : recip_q;
      pa_l  = sub_en ? row_ca[ci_l] : mat_a[col_q][ci_l];
      pb_l  = sub_en ? row_cb[ci_l] : mat_b[col_q][ci_l];
      acc_a = sub_en ? mat_a[row_q][ci_l] : '0;
      acc_b = sub_en ? mat_b[row_q][ci_l] : '0;
      wb_col[l] = int'(wb_ch_q) * LANES + l;
      wb_ok[l]  = wb_col[l] < int'(n_q);
      ya_mag[l] = mag(ya[l]);
    end
    gj_lane #(.DW(DW), .FB(FB)) i_lane_a (
      .clk_i, .rst_ni, .sub_i(sub_en), .acc_i(acc_a), .mul_a_i(m_l),
      .mul_b_i(pa_l), .y_o(ya[l]));
    gj_lane #(.DW(DW), .FB(FB)) i_lane_b (
      .clk_i, .rst_ni, .sub_i(sub_en), .acc_i(acc_b), .mul_a_i(m_l),
      .mul_b_i(pb_l), .y_o(yb[l]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= S_IDLE; n_q <= '0; col_q <= '0; row_q <= '0; ch_q <= '0;
      piv_row_q <= '0; piv_mag_q <= '0; recip_q <= '0; rec_neg_q <= 1'b0;
      wb_val_q <= 1'b0; wb_norm_q <= 1'b0; wb_row_q <= '0; wb_ch_q <= '0;
      done_o <= 1'b0; singular_o <= 1'b0;
      for (int r = 0; r < N_MAX; r++) begin
        row_ca[r] <= '0; row_cb[r] <= '0; col_c[r] <= '0;
        for (int c = 0; c < N_MAX; c++) begin
          mat_a[r][c] <= '0; mat_b[r][c] <= '0;
        end
      end
    end else begin
      if (ld_en_i) begin
        for (int c = 0; c < N_MAX; c++) begin
          mat_a[ld_row_i][c] <= ld_data_i[c*DW +: DW];
          mat_b[ld_row_i][c] <= (c == int'(ld_row_i)) ? ONE : '0;
        end
        // column-0 pivot tracked while rows arrive
        if (ld_row_i == '0 || ld_mag > piv_mag_q) begin
          piv_mag_q <= ld_mag;
          piv_row_q <= ld_row_i;
        end
      end
      if (wb_val_q) begin
        for (int l = 0; l < LANES; l++) begin
          if (wb_ok[l]) begin
            mat_a[wb_tgt][wb_col[l]] <= ya[l];
            mat_b[wb_tgt][wb_col[l]] <= yb[l];
            if (wb_norm_q) begin
              row_ca[wb_col[l]] <= ya[l];
              row_cb[wb_col[l]] <= yb[l];
            end else if (wb_col[l] == int'(col_q) + 1 && wb_row_q > col_q &&
                         ya_mag[l] > piv_mag_q) begin
              // tail comparator picks the next pivot
              piv_mag_q <= ya_mag[l];
              piv_row_q <= wb_row_q;
            end
          end
        end
      end
      wb_val_q  <= issue;
      wb_norm_q <= (state == S_NORM);
      wb_row_q  <= row_q;
      wb_ch_q   <= ch_q;
      case (state)
        S_IDLE: if (start_i) begin
          state <= S_SWAP; n_q <= n_i; col_q <= '0;
          done_o <= 1'b0; singular_o <= 1'b0;
        end
        S_SWAP: if (piv_val == '0) begin
          state <= S_IDLE; done_o <= 1'b1; singular_o <= 1'b1;
        end else begin
          for (int c = 0; c < N_MAX; c++) begin
            mat_a[col_q][c]     <= mat_a[piv_row_q][c];
            mat_a[piv_row_q][c] <= mat_a[col_q][c];
            mat_b[col_q][c]     <= mat_b[piv_row_q][c];
            mat_b[piv_row_q][c] <= mat_b[col_q][c];
          end
          rec_neg_q <= piv_val[DW-1];
          state     <= S_RECIP;
        end
        S_RECIP: begin
          for (int k = 0; k < N_MAX; k++) col_c[k] <= mat_a[k][col_q];
          if (rec_valid) begin
            recip_q <= rec_neg_q ? -rec_q : rec_q;
            ch_q    <= '0;
            state   <= S_NORM;
          end
        end
        S_NORM: if (last_ch) state <= S_NWAIT;
                else ch_q <= ch_q + CHW'(1);
        S_NWAIT: begin
          row_q <= '0; ch_q <= '0; piv_mag_q <= '0;
          piv_row_q <= col_q + RW'(1);
          state <= S_ELIM;
        end
        S_ELIM: if (row_q == col_q || last_ch) begin
          ch_q <= '0;
          if (int'(row_q) == int'(n_q) - 1) state <= S_DRAIN;
          else row_q <= row_q + RW'(1);
        end else ch_q <= ch_q + CHW'(1);
        S_DRAIN: if (int'(col_q) == int'(n_q) - 1) begin
          state <= S_IDLE; done_o <= 1'b1;
        end else begin
          col_q <= col_q + RW'(1);
          state <= S_SWAP;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_sing_with_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    singular_o |-> done_o);
  p_done_when_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  p_recip_ready_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == S_NORM) |-> (recip_q != '0));
  p_col_in_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (int'(col_q) < int'(n_q)));
  p_start_ignored_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(n_q));
endmodule

// File: tb/test_gj_inverter.sv
module test_gj_inverter;
  localparam int N_MAX = 4, DW = 24, FB = 12, LANES = 2;
  localparam int RW = $clog2(N_MAX), NW = $clog2(N_MAX+1);
  localparam int NCASE = 7;
  // n, 16 entries in quarter units (row-major, stride 4), expected singular
  localparam int TV [NCASE][18] = '{
    '{4, 16,4,0,8,   4,12,4,0,  0,4,8,4,   8,0,4,20, 0},
    '{4, 0,4,0,0,    0,0,0,-4,  8,0,0,0,   0,0,2,0,  0},
    '{3, -4,2,8,0,   12,4,-4,0, 1,-8,4,0,  0,0,0,0,  0},
    '{2, 8,4,0,0,    4,4,0,0,   0,0,0,0,   0,0,0,0,  0},
    '{1, -8,0,0,0,   0,0,0,0,   0,0,0,0,   0,0,0,0,  0},
    '{3, 4,0,8,0,    8,0,4,0,   16,0,12,0, 0,0,0,0,  1},
    '{2, 0,0,0,0,    0,0,0,0,   0,0,0,0,   0,0,0,0,  1}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, ld_en = 1'b0;
  logic [NW-1:0] n_sel = '0;
  logic [RW-1:0] ld_row = '0, rd_row = '0, rd_col = '0;
  logic [N_MAX*DW-1:0] ld_data = '0;
  logic signed [DW-1:0] rd_data;
  logic busy, done, sing;
  int n_tests = 0, n_fail = 0;
  real refb [4][4];

  always #10 clk = ~clk;

  gj_inverter #(.N_MAX(N_MAX), .DW(DW), .FB(FB), .LANES(LANES)) i_gj_inverter (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .n_i(n_sel), .ld_en_i(ld_en),
    .ld_row_i(ld_row), .ld_data_i(ld_data), .rd_row_i(rd_row), .rd_col_i(rd_col),
    .rd_data_o(rd_data), .busy_o(busy), .done_o(done), .singular_o(sing));

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic real rabs(input real v);
    return (v < 0.0) ? -v : v;
  endfunction

  function automatic int exp_cycles(input int n);
    return n * (2*FB + 6 + n * ((n + LANES - 1) / LANES));
  endfunction

  task automatic ref_inv(input int cs, output bit s);
    int n = TV[cs][0];
    real a [4][4];
    s = 1'b0;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) begin
        a[r][c] = TV[cs][1 + r*4 + c] / 4.0;
        refb[r][c] = (r == c) ? 1.0 : 0.0;
      end
    for (int i = 0; i < n; i++) begin
      int p = i;
      real f;
      for (int j = i + 1; j < n; j++) if (rabs(a[j][i]) > rabs(a[p][i])) p = j;
      if (rabs(a[p][i]) < 1.0e-9) begin s = 1'b1; return; end
      for (int c = 0; c < n; c++) begin
        real t = a[i][c]; a[i][c] = a[p][c]; a[p][c] = t;
        t = refb[i][c]; refb[i][c] = refb[p][c]; refb[p][c] = t;
      end
      f = a[i][i];
      for (int c = 0; c < n; c++) begin a[i][c] = a[i][c] / f; refb[i][c] = refb[i][c] / f; end
      for (int k = 0; k < n; k++) if (k != i) begin
        f = a[k][i];
        for (int c = 0; c < n; c++) begin
          a[k][c] = a[k][c] - f * a[i][c];
          refb[k][c] = refb[k][c] - f * refb[i][c];
        end
      end
    end
  endtask

  task automatic load_case(input int cs);
    int n = TV[cs][0];
    for (int r = 0; r < n; r++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_row = RW'(r);
      for (int c = 0; c < N_MAX; c++)
        ld_data[c*DW +: DW] = (c < n) ? DW'(TV[cs][1 + r*4 + c] * (1 << (FB-2))) : '0;
    end
    @(negedge clk); ld_en = 1'b0;
  endtask

  task automatic run(input int n, output int cyc);
    @(negedge clk); start = 1'b1; n_sel = NW'(n);
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    cyc = 0;
    while (!done) begin @(posedge clk); cyc++; @(negedge clk); end
  endtask

  task automatic check_result(input int cs, input string req);
    int n = TV[cs][0];
    for (int r = 0; r < n; r++)
      for (int c = 0; c < n; c++) begin
        int e, g;
        rd_row = RW'(r); rd_col = RW'(c); #1;
        g = int'(rd_data);
        e = $rtoi(refb[r][c] * 4096.0 + ((refb[r][c] >= 0.0) ? 0.5 : -0.5));
        check((g - e <= 16) && (e - g <= 16), req, $sformatf("case %0d inv[%0d][%0d]", cs, r, c), g, e);
      end
  endtask

  initial begin
    #(20 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int cyc;
    bit s;
    string req;
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R1: outputs quiet after reset
    check(!busy && !done && !sing, "R1", "reset flags", {busy, done, sing}, 0);
    rst_n = 1'b1;

    for (int cs = 0; cs < NCASE; cs++) begin
      int n = TV[cs][0];
      // case 1 needs the load-time pivot (R4), case 2 swaps (R3), smaller sizes R7
      req = (cs == 1) ? "R4" : (cs == 2) ? "R3" : (cs >= 3) ? "R7" : "R2";
      ref_inv(cs, s);
      load_case(cs);
      run(n, cyc);
      check(sing == TV[cs][17][0], "R5", $sformatf("case %0d singular", cs), sing, TV[cs][17]);
      if (!s) begin
        check(cyc == exp_cycles(n), "R8", $sformatf("case %0d done latency", cs), cyc, exp_cycles(n));
        check_result(cs, req);
      end else begin
        check(done && sing, "R5", $sformatf("case %0d done with singular", cs), {done, sing}, 3);
      end
    end

    // R9: reciprocal truncation, 1x1 holding 3.0
    @(negedge clk);
    ld_en = 1'b1; ld_row = '0; ld_data = '0; ld_data[DW-1:0] = DW'(3 << FB);
    @(negedge clk); ld_en = 1'b0;
    run(1, cyc);
    rd_row = '0; rd_col = '0; #1;
    check(int'(rd_data) == (1 << (2*FB)) / (3 << FB), "R9", "1/3 code", int'(rd_data), (1 << (2*FB)) / (3 << FB));

    // R6: stray start mid-run with another size
    ref_inv(3, s);
    load_case(3);
    @(negedge clk); start = 1'b1; n_sel = NW'(2);
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    cyc = 0;
    while (!done) begin
      @(posedge clk); cyc++;
      @(negedge clk);
      if (cyc == 5) begin start = 1'b1; n_sel = NW'(1); end
      else start = 1'b0;
    end
    start = 1'b0;
    check(cyc == exp_cycles(2), "R6", "latency with stray start", cyc, exp_cycles(2));
    check(!sing, "R6", "singular after stray start", sing, 0);
    check_result(3, "R6");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule